// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Buffer Status Flags

This block sends and receives asynchronous serial frames for a processor. A single data location is shared: a write puts a byte into a transmit holding buffer, and a read takes the byte out of a separate receive buffer. The transmitter moves the held byte into its own shift register as soon as it is idle. It then drives a frame of a low start bit, the data bits least significant first, an optional parity bit and one high stop bit.

The receiver oversamples the line and confirms each start bit half a bit after the falling edge, which rejects short glitches. It samples every later bit at its centre and removes the framing bits. It stores the byte together with a parity-error and a framing-error indication. Bit timing comes from an external baud generator, which supplies a one-cycle enable pulse `OVS` times per bit.

Status comes out as level flags. One flag shows unread receive data, one shows a finished transmission and one shows a free transmit holding buffer. Each flag has its own set and clear rules. Dropping the receive enable flushes any unread byte.

Top module: `sp_uart_core`

## Requirements
- R1: The serial output idles high. Each transmitted frame is a low start bit, then `DATA_W` data bits with the least significant bit first, then a parity bit if parity is on, then one high stop bit. Each bit lasts `OVS` baud ticks.
- R2: `par_mode` selects the parity: 2'b00 is none, 2'b01 is even and 2'b10 is odd; 2'b11 behaves as none. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number.
- R3: After a falling edge on the serial input, the receiver checks the line `OVS/2` ticks later. A low pulse that has ended by then is ignored and yields no byte.
- R4: The receiver samples each data and parity bit at its centre and delivers only the data bits, in order, on `bus_rdata`. `rx_par_err` is high with that byte when the received parity bit differs from the bit `par_mode` requires.
- R5: When the stop bit is sampled low, `rx_frame_err` is high together with that received byte.
- R6: `rx_done` is high while an unread byte is in the receive buffer. A `bus_rd` clears it at the next clock edge. The error flags read low whenever `rx_done` is low.
- R7: While `rx_en` is low, the receive buffer is flushed at the next edge, `rx_done` stays low and incoming frames are ignored.
- R8: `tx_empty` is high while the transmit holding buffer is free. A `bus_wr` with `tx_en` high and the buffer free loads it, and `tx_empty` is low after that edge. A write while the buffer is full, or while `tx_en` is low, is ignored.
- R9: `tx_done` goes high after a frame's stop bit when no further byte is waiting. It stays high until `txc_ack`.
- R10: A byte written while a frame is being shifted starts right after that frame's stop bit. The receiver accepts a start bit that directly follows a stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable pulse, OVS per bit |
| rx_en | input | 1 | Receiver enable; low flushes the receive buffer |
| tx_en | input | 1 | Transmitter enable for data writes |
| par_mode | input | 2 | Parity select (none, even, odd) |
| bus_wr | input | 1 | Write strobe to the data location |
| bus_rd | input | 1 | Read strobe from the data location |
| bus_wdata | input | DATA_W | Byte to transmit |
| bus_rdata | output | DATA_W | Received byte |
| txc_ack | input | 1 | Service acknowledge that clears tx_done |
| rx_line | input | 1 | Serial input |
| tx_line | output | 1 | Serial output |
| rx_done | output | 1 | Unread byte present |
| rx_frame_err | output | 1 | Framing error of the buffered byte |
| rx_par_err | output | 1 | Parity error of the buffered byte |
| tx_done | output | 1 | Transmission finished, nothing pending |
| tx_empty | output | 1 | Transmit holding buffer free |

## Verification
Buffer flags move one clock after the strobe that causes them. `tx_empty` falls one edge after an accepted write and rises on the next edge, when the byte moves into the shifter and the start bit appears. `rx_done` clears one edge after a read or after `rx_en` falls. The bench samples these on the falling clock edge right after the strobe. The serial results are due much later: a received byte about half a bit after its stop bit begins, and `tx_done` one clock after the stop bit ends. The scoreboard therefore waits for `rx_done`, and a line monitor times the transmitted bits from the start edge at bit centres, `OVS` ticks apart. Back-to-back transmission is bounded by the measured time from first write to `tx_done`.

// File: rtl/sp_uart_pkg.sv
package sp_uart_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2
   } par_mode_e;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_START,
      FS_DATA,
      FS_PAR,
      FS_STOP
   } frame_st_e;

   // Returns 1 when the mode adds a parity bit.
   function automatic logic par_on(input logic [1:0] m);
      return (par_mode_e'(m) == PAR_EVEN) || (par_mode_e'(m) == PAR_ODD);
   endfunction

   // Parity bit value, given the XOR of the data bits.
   function automatic logic par_value(input logic data_xor, input logic [1:0] m);
      return (par_mode_e'(m) == PAR_ODD) ? ~data_xor : data_xor;
   endfunction

endpackage

// File: rtl/sp_uart_sync.sv
module sp_uart_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[g] <= 1'b1;
            end else begin
               chain[g] <= (g == 0) ? d : chain[(g == 0) ? 0 : g-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_uart_tx.sv
module sp_uart_tx
   import sp_uart_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        par_mode,
   input  logic              load_req,
   input  logic [DATA_W-1:0] load_data,
   output logic              load_ack,
   output logic              line,
   output logic              fin
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   frame_st_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic              pen;

   assign load_ack = (st == FS_IDLE) && load_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= FS_IDLE;
         cnt   <= '0;
         idx   <= '0;
         shreg <= '0;
         pbit  <= 1'b0;
         pen   <= 1'b0;
         line  <= 1'b1;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (st == FS_IDLE) begin
            if (load_req) begin
               st    <= FS_START;
               line  <= 1'b0;
               shreg <= load_data;
               pbit  <= par_value(^load_data, par_mode);
               pen   <= par_on(par_mode);
               cnt   <= '0;
            end
         end else if (tick) begin
            if (cnt != CNT_LAST) begin
               cnt <= cnt + 1'b1;
            end else begin
               cnt <= '0;
               unique case (st)
                  FS_START: begin
                     st    <= FS_DATA;
                     idx   <= '0;
                     line  <= shreg[0];
                     shreg <= shreg >> 1;
                  end
                  FS_DATA: begin
                     if (idx == IDX_LAST) begin
                        st   <= pen ? FS_PAR : FS_STOP;
                        line <= pen ? pbit : 1'b1;
                     end else begin
                        idx   <= idx + 1'b1;
                        line  <= shreg[0];
                        shreg <= shreg >> 1;
                     end
                  end
                  FS_PAR: begin
                     st   <= FS_STOP;
                     line <= 1'b1;
                  end
                  FS_STOP: begin
                     st  <= FS_IDLE;
                     fin <= 1'b1;
                  end
                  default: st <= FS_IDLE;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/sp_uart_rx.sv
module sp_uart_rx
   import sp_uart_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic [1:0]        par_mode,
   input  logic              line_s,
   output logic              fin,
   output logic [DATA_W-1:0] data,
   output logic              ferr,
   output logic              perr
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS/2 - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   frame_st_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;
   logic              perr_q;

   assign data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= FS_IDLE;
         cnt    <= '0;
         idx    <= '0;
         shreg  <= '0;
         perr_q <= 1'b0;
         fin    <= 1'b0;
         ferr   <= 1'b0;
         perr   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (!en) begin
            st <= FS_IDLE;
         end else if (st == FS_IDLE) begin
            if (!line_s) begin
               st     <= FS_START;
               cnt    <= '0;
               perr_q <= 1'b0;
            end
         end else if (tick) begin
            if (st == FS_START) begin
               if (cnt == CNT_HALF) begin
                  cnt <= '0;
                  idx <= '0;
                  st  <= line_s ? FS_IDLE : FS_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else if (cnt != CNT_LAST) begin
               cnt <= cnt + 1'b1;
            end else begin
               cnt <= '0;
               unique case (st)
                  FS_DATA: begin
                     shreg <= {line_s, shreg[DATA_W-1:1]};
                     if (idx == IDX_LAST) begin
                        st <= par_on(par_mode) ? FS_PAR : FS_STOP;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end
                  FS_PAR: begin
                     perr_q <= line_s != par_value(^shreg, par_mode);
                     st     <= FS_STOP;
                  end
                  FS_STOP: begin
                     fin  <= 1'b1;
                     ferr <= ~line_s;
                     perr <= perr_q;
                     st   <= FS_IDLE;
                  end
                  default: st <= FS_IDLE;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/sp_uart_core.sv
module sp_uart_core #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic [1:0]        par_mode,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              txc_ack,
   input  logic              rx_line,
   output logic              tx_line,
   output logic              rx_done,
   output logic              rx_frame_err,
   output logic              rx_par_err,
   output logic              tx_done,
   output logic              tx_empty
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("DATA_W must lie between 5 and 9");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rx_s;
   logic              hold_full;
   logic [DATA_W-1:0] hold_q;
   logic              load_ack;
   logic              tx_fin;
   logic              rx_fin;
   logic [DATA_W-1:0] rx_data;
   logic              rx_ferr;
   logic              rx_perr;
   logic              rbuf_full;
   logic [DATA_W-1:0] rbuf_q;
   logic              rbuf_fe;
   logic              rbuf_pe;
   logic              txc_q;

   sp_uart_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
   );

   sp_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .par_mode(par_mode),
      .load_req(hold_full), .load_data(hold_q), .load_ack(load_ack),
      .line(tx_line), .fin(tx_fin)
   );

   sp_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) rx_i (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_en),
      .par_mode(par_mode), .line_s(rx_s), .fin(rx_fin),
      .data(rx_data), .ferr(rx_ferr), .perr(rx_perr)
   );

   // Transmit holding buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_q    <= '0;
      end else if (bus_wr && tx_en && !hold_full) begin
         hold_full <= 1'b1;
         hold_q    <= bus_wdata;
      end else if (load_ack) begin
         hold_full <= 1'b0;
      end
   end

   // Transmission-finished flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txc_q <= 1'b0;
      end else if (tx_fin && !hold_full) begin
         txc_q <= 1'b1;
      end else if (txc_ack) begin
         txc_q <= 1'b0;
      end
   end

   // Receive buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbuf_full <= 1'b0;
         rbuf_q    <= '0;
         rbuf_fe   <= 1'b0;
         rbuf_pe   <= 1'b0;
      end else if (!rx_en) begin
         rbuf_full <= 1'b0;
      end else if (rx_fin) begin
         rbuf_full <= 1'b1;
         rbuf_q    <= rx_data;
         rbuf_fe   <= rx_ferr;
         rbuf_pe   <= rx_perr;
      end else if (bus_rd) begin
         rbuf_full <= 1'b0;
      end
   end

   assign bus_rdata    = rbuf_q;
   assign rx_done      = rbuf_full;
   assign rx_frame_err = rbuf_full & rbuf_fe;
   assign rx_par_err   = rbuf_full & rbuf_pe;
   assign tx_done      = txc_q;
   assign tx_empty     = ~hold_full;
endmodule

// File: rtl/sp_uart_chk.sv
module sp_uart_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_en,
   input logic tx_en,
   input logic bus_wr,
   input logic bus_rd,
   input logic txc_ack,
   input logic tx_empty,
   input logic tx_done,
   input logic rx_done,
   input logic tx_fin,
   input logic rx_fin
);
   assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_done);

   assert_no_rx_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_fin);

   assert_write_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && tx_en && tx_empty) |=> !tx_empty);

   assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (txc_ack && !tx_fin) |=> !tx_done);

   assert_read_pops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && rx_done && !rx_fin) |=> !rx_done);
endmodule

bind sp_uart_core sp_uart_chk chk_i (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .txc_ack(txc_ack),
   .tx_empty(tx_empty), .tx_done(tx_done), .rx_done(rx_done),
   .tx_fin(tx_fin), .rx_fin(rx_fin)
);

// File: tb/sp_uart_core_tb.sv
`timescale 1ns/1ps
module sp_uart_core_tb_top;
   localparam int DW  = 8;
   localparam int BIT = 64;   // 16 ticks of 4 clocks

   typedef struct {
      logic [DW-1:0] data;
      logic          fe;
      logic          pe;
   } rx_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic rx_en = 1'b0, tx_en = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic bus_wr = 1'b0, bus_rd = 1'b0, txc_ack = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic rx_line = 1'b1;
   logic tx_line, rx_done, rx_frame_err, rx_par_err, tx_done, tx_empty;

   int n_checks = 0, n_fail = 0;
   logic [1:0] tcnt = '0;
   logic mon_hold = 1'b0;
   rx_item_t rxq[$];
   logic [DW-1:0] txq[$];

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      tcnt      <= tcnt + 1'b1;
      baud_tick <= (tcnt == 2'd3);
   end

   sp_uart_core dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en),
      .tx_en(tx_en), .par_mode(par_mode), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txc_ack(txc_ack),
      .rx_line(rx_line), .tx_line(tx_line), .rx_done(rx_done),
      .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err),
      .tx_done(tx_done), .tx_empty(tx_empty)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic pbit(input logic [DW-1:0] d, input logic [1:0] m);
      return (m == 2'b10) ? ~(^d) : (^d);
   endfunction

   // Serial driver into rx_line; pushes the expected item when asked
   task automatic send_rx(input logic [DW-1:0] d, input bit bad_par,
                          input bit bad_stop, input bit push, input bit gap);
      rx_item_t it;
      it.data = d;
      it.fe   = bad_stop;
      it.pe   = bad_par && (par_mode == 2'b01 || par_mode == 2'b10);
      if (push) rxq.push_back(it);
      @(negedge clk);
      rx_line = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < DW; i++) begin
         rx_line = d[i];
         repeat (BIT) @(negedge clk);
      end
      if (par_mode == 2'b01 || par_mode == 2'b10) begin
         rx_line = pbit(d, par_mode) ^ bad_par;
         repeat (BIT) @(negedge clk);
      end
      if (bad_stop) begin
         rx_line = 1'b0;
         repeat (40) @(negedge clk);
         rx_line = 1'b1;
         repeat (2*BIT) @(negedge clk);
      end else begin
         rx_line = 1'b1;
         repeat (BIT - 1) @(negedge clk);
      end
      if (gap) repeat (BIT) @(negedge clk);
   endtask

   // Receive scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !mon_hold && rx_done) begin
            if (rxq.size() == 0) begin
               check(1'b0, "R3 unexpected byte", bus_rdata, 0);
            end else begin
               rx_item_t e;
               e = rxq.pop_front();
               check(bus_rdata == e.data, "R4 rx data", bus_rdata, e.data);
               check(rx_par_err == e.pe, "R4 parity flag", rx_par_err, e.pe);
               check(rx_frame_err == e.fe, "R5 frame flag", rx_frame_err, e.fe);
            end
            bus_rd = 1'b1;
            @(negedge clk);
            bus_rd = 1'b0;
            check(!rx_done, "R6 read clears rx_done", rx_done, 0);
         end
      end
   end

   // Transmit line monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && tx_line == 1'b0) begin
            logic [DW-1:0] got;
            logic          pb;
            logic [DW-1:0] e;
            logic [1:0]    m;
            m = par_mode;
            repeat (BIT/2 - 1) @(negedge clk);
            check(tx_line == 1'b0, "R1 start bit", tx_line, 0);
            for (int i = 0; i < DW; i++) begin
               repeat (BIT) @(negedge clk);
               got[i] = tx_line;
            end
            if (m == 2'b01 || m == 2'b10) begin
               repeat (BIT) @(negedge clk);
               pb = tx_line;
               check(pb == pbit(got, m), "R2 tx parity bit", pb, pbit(got, m));
            end
            repeat (BIT) @(negedge clk);
            check(tx_line == 1'b1, "R1 stop bit", tx_line, 1);
            if (txq.size() == 0) begin
               check(1'b0, "R8 unexpected tx frame", got, 0);
            end else begin
               e = txq.pop_front();
               check(got == e, "R1 tx data LSB first", got, e);
            end
         end
      end
   end

   task automatic write_tx(input logic [DW-1:0] d);
      @(negedge clk);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic wait_txdone(output int cycles);
      cycles = 0;
      while (!tx_done && cycles < 3000) begin
         @(negedge clk);
         cycles++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int cyc;
      repeat (10) @(negedge clk);
      check(tx_line == 1'b1, "R1 idle line after reset", tx_line, 1);
      check(tx_empty == 1'b1, "R8 empty after reset", tx_empty, 1);
      check(tx_done == 1'b0, "R9 tx_done low after reset", tx_done, 0);
      check(rx_done == 1'b0, "R6 rx_done low after reset", rx_done, 0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      tx_en = 1'b1;
      repeat (10) @(negedge clk);

      // R4: plain reception
      send_rx(8'hA5, 0, 0, 1, 1);
      send_rx(8'h3C, 0, 0, 1, 1);
      // R2 / R4: parity modes
      par_mode = 2'b01;
      send_rx(8'h5A, 0, 0, 1, 1);
      send_rx(8'h81, 1, 0, 1, 1);
      par_mode = 2'b10;
      send_rx(8'h7E, 0, 0, 1, 1);
      send_rx(8'h00, 1, 0, 1, 1);
      par_mode = 2'b00;
      // R5: framing error
      send_rx(8'h96, 0, 1, 1, 1);
      // R3: short glitch rejected
      @(negedge clk);
      rx_line = 1'b0;
      repeat (16) @(negedge clk);
      rx_line = 1'b1;
      repeat (5*BIT) @(negedge clk);
      check(rx_done == 1'b0 && rxq.size() == 0, "R3 glitch ignored", rx_done, 0);
      // R10: start bit directly after stop bit
      send_rx(8'hC7, 0, 0, 1, 0);
      send_rx(8'h18, 0, 0, 1, 1);
      repeat (BIT) @(negedge clk);
      check(rxq.size() == 0, "R10 back-to-back rx frames", rxq.size(), 0);

      // R6 / R7: unread byte then flush
      mon_hold = 1'b1;
      send_rx(8'h42, 0, 0, 0, 1);
      check(rx_done == 1'b1, "R6 rx_done while unread", rx_done, 1);
      check(bus_rdata == 8'h42, "R6 rdata holds byte", bus_rdata, 8'h42);
      rx_en = 1'b0;
      @(negedge clk);
      check(rx_done == 1'b0, "R7 flush on disable", rx_done, 0);
      send_rx(8'h11, 0, 0, 0, 1);
      check(rx_done == 1'b0, "R7 frame ignored while off", rx_done, 0);
      rx_en = 1'b1;
      repeat (4) @(negedge clk);
      check(rx_done == 1'b0, "R7 nothing after re-enable", rx_done, 0);
      mon_hold = 1'b0;

      // R1 / R8 / R9: single transmit
      txq.push_back(8'hC3);
      @(negedge clk);
      bus_wdata = 8'hC3;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      check(tx_empty == 1'b0, "R8 buffer full after write", tx_empty, 0);
      @(negedge clk);
      check(tx_empty == 1'b1, "R8 buffer freed on load", tx_empty, 1);
      check(tx_line == 1'b0, "R1 start bit begins", tx_line, 0);
      check(tx_done == 1'b0, "R9 tx_done low while sending", tx_done, 0);
      wait_txdone(cyc);
      check(tx_done == 1'b1, "R9 tx_done after frame", tx_done, 1);
      repeat (BIT) @(negedge clk);
      check(tx_done == 1'b1, "R9 tx_done holds", tx_done, 1);
      txc_ack = 1'b1;
      @(negedge clk);
      txc_ack = 1'b0;
      check(tx_done == 1'b0, "R9 ack clears", tx_done, 0);

      // R8 / R10: back-to-back even parity, third write while full
      par_mode = 2'b01;
      txq.push_back(8'h5F);
      txq.push_back(8'h3A);
      write_tx(8'h5F);
      write_tx(8'h3A);
      check(tx_empty == 1'b0, "R8 second byte held", tx_empty, 0);
      write_tx(8'h77);
      check(tx_empty == 1'b0, "R8 still full", tx_empty, 0);
      repeat (11*BIT) @(negedge clk);
      check(tx_done == 1'b0, "R9 no tx_done with byte pending", tx_done, 0);
      wait_txdone(cyc);
      check(cyc < 11*BIT + 40, "R10 second frame follows at once", cyc, 11*BIT);
      repeat (BIT) @(negedge clk);
      check(txq.size() == 0, "R10 both frames seen", txq.size(), 0);
      txc_ack = 1'b1;
      @(negedge clk);
      txc_ack = 1'b0;

      // R2: odd parity transmit
      par_mode = 2'b10;
      txq.push_back(8'h0F);
      write_tx(8'h0F);
      wait_txdone(cyc);
      check(tx_done == 1'b1, "R2 odd frame done", tx_done, 1);
      repeat (BIT) @(negedge clk);
      txc_ack = 1'b1;
      @(negedge clk);
      txc_ack = 1'b0;
      par_mode = 2'b00;

      // R8: write ignored while transmitter disabled
      tx_en = 1'b0;
      write_tx(8'h99);
      check(tx_empty == 1'b1, "R8 write ignored when disabled", tx_empty, 1);
      cyc = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (tx_line == 1'b0) cyc++;
      end
      check(cyc == 0, "R8 line stays idle when disabled", cyc, 0);
      check(txq.size() == 0 && rxq.size() == 0, "R1 scoreboards drained",
            txq.size() + rxq.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule